// File: doc/BRIEF.md
# Status Flag Execute Unit

This block executes the one-byte instructions that act only on the status flags and on the two low bytes of the accumulator. The operations are: carry complement, carry set and clear, interrupt-enable set and clear, direction set and clear, the two transfers between AH and the low byte of the flags, and filling AL from the carry flag. Each cycle the pipeline may present a valid strobe together with the opcode byte, the current flags word and the current AL and AH values. One clock edge later the unit returns the next flags, AL and AH values. It also returns a write enable for each of the three destinations and a flag for any opcode outside its set.

The set and clear opcodes come in pairs whose members differ only in bit 0. The unit takes the new flag value straight from that opcode bit. The flag byte shared with AH has a fixed layout in which three positions are reserved. On both transfers these positions are forced to fixed constants: bit 1 is 1, bits 3 and 5 are 0. The reset input is asynchronous and active low. Its release is synchronised inside the block. Privilege checks and interrupt-shadow timing are handled elsewhere.

Top module: `flag_exec_unit`

## Requirements
- R1: After reset every output is 0: all write enables, the unsupported flag, and the flags, AL and AH result values.
- R2: Opcode 0xF5 inverts the carry flag (flags bit 0). All other flag bits are returned unchanged and only the flags write enable is raised.
- R3: Opcodes 0xF8 and 0xF9 write carry (flags bit 0) with opcode bit 0. 0xF8 gives 0 and 0xF9 gives 1. The rest of the flags is unchanged and only the flags write enable is raised.
- R4: Opcodes 0xFA and 0xFB write interrupt enable (flags bit 9) with opcode bit 0. The rest of the flags is unchanged and only the flags write enable is raised.
- R5: Opcodes 0xFC and 0xFD write direction (flags bit 10) with opcode bit 0, where 0 means increment and 1 means decrement. The rest of the flags is unchanged and only the flags write enable is raised.
- R6: Opcode 0x9E loads flags bits 7..0 from AH as {AH7, AH6, 0, AH4, 0, AH2, 1, AH0}. Flags bits above 7 are unchanged and only the flags write enable is raised.
- R7: Opcode 0x9F returns AH = {F7, F6, 0, F4, 0, F2, 1, F0}, where Fn is flags bit n. The flags are unchanged and only the AH write enable is raised.
- R8: Opcode 0xD6 returns AL = 0xFF when carry is 1 and AL = 0x00 when carry is 0. The flags are unchanged and only the AL write enable is raised.
- R9: Any other opcode with valid high raises the unsupported flag, keeps all write enables low, and returns the input flags, AL and AH unchanged.
- R10: The results appear exactly one clock edge after the valid input. A cycle with valid low gives all write enables low and the unsupported flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is present this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_flags | input | FLAG_W | Current flags word |
| in_al | input | 8 | Current AL |
| in_ah | input | 8 | Current AH |
| out_flags | output | FLAG_W | Next flags value |
| out_al | output | 8 | Next AL value |
| out_ah | output | 8 | Next AH value |
| out_flags_we | output | 1 | Write enable for the flags |
| out_al_we | output | 1 | Write enable for AL |
| out_ah_we | output | 1 | Write enable for AH |
| out_unsupported | output | 1 | Opcode is not in the supported set |

## Verification
The hardest case to reach is a reserved flag position being forced by a transfer. The forced value only shows when the source byte already holds the opposite value in that position. Constant or zero operands would therefore hide a missing force. The stimulus sweeps all 256 opcodes against several flag and AH patterns, including all-ones, all-zeros and alternating bits, so every reserved position is seen both set and clear. Idle cycles placed between some instructions show that the write enables drop when valid is low.

// File: rtl/flag_exec_pkg.sv
package flag_exec_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_CMC,
    K_CARRY,
    K_IFLAG,
    K_DFLAG,
    K_LOADF,
    K_STOREF,
    K_FILLAL
  } op_kind_e;

  localparam int unsigned CARRY_BIT = 0;
  localparam int unsigned IEN_BIT   = 9;
  localparam int unsigned DIR_BIT   = 10;

  // Map a byte onto the shared flag byte layout, forcing the reserved slots.
  function automatic logic [7:0] fix_flag_byte(input logic [7:0] b);
    return {b[7], b[6], 1'b0, b[4], 1'b0, b[2], 1'b1, b[0]};
  endfunction

endpackage

// File: rtl/flag_exec_rst_sync.sv
module flag_exec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/flag_exec_decode.sv
module flag_exec_decode
  import flag_exec_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_e   kind
);
  always_comb begin
    unique case (opcode)
      8'hF5:        kind = K_CMC;
      8'hF8, 8'hF9: kind = K_CARRY;
      8'hFA, 8'hFB: kind = K_IFLAG;
      8'hFC, 8'hFD: kind = K_DFLAG;
      8'h9E:        kind = K_LOADF;
      8'h9F:        kind = K_STOREF;
      8'hD6:        kind = K_FILLAL;
      default:      kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/flag_exec_datapath.sv
module flag_exec_datapath
  import flag_exec_pkg::*;
#(
  parameter int unsigned FLAG_W = 16
) (
  input  op_kind_e          kind,
  input  logic              op_lsb,
  input  logic              valid,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [7:0]        al_i,
  input  logic [7:0]        ah_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [7:0]        al_o,
  output logic [7:0]        ah_o,
  output logic              flags_we_o,
  output logic              al_we_o,
  output logic              ah_we_o,
  output logic              unsup_o
);
  always_comb begin
    flags_o    = flags_i;
    al_o       = al_i;
    ah_o       = ah_i;
    flags_we_o = 1'b0;
    al_we_o    = 1'b0;
    ah_we_o    = 1'b0;
    unsup_o    = 1'b0;
    unique case (kind)
      K_CMC: begin
        flags_o[CARRY_BIT] = ~flags_i[CARRY_BIT];
        flags_we_o         = valid;
      end
      K_CARRY: begin
        flags_o[CARRY_BIT] = op_lsb;
        flags_we_o         = valid;
      end
      K_IFLAG: begin
        flags_o[IEN_BIT] = op_lsb;
        flags_we_o       = valid;
      end
      K_DFLAG: begin
        flags_o[DIR_BIT] = op_lsb;
        flags_we_o       = valid;
      end
      K_LOADF: begin
        flags_o[7:0] = fix_flag_byte(ah_i);
        flags_we_o   = valid;
      end
      K_STOREF: begin
        ah_o    = fix_flag_byte(flags_i[7:0]);
        ah_we_o = valid;
      end
      K_FILLAL: begin
        al_o    = {8{flags_i[CARRY_BIT]}};
        al_we_o = valid;
      end
      default: unsup_o = valid;
    endcase
  end
endmodule

// File: rtl/flag_exec_unit.sv
module flag_exec_unit
  import flag_exec_pkg::*;
#(
  parameter int unsigned FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [7:0]        in_al,
  input  logic [7:0]        in_ah,
  output logic [FLAG_W-1:0] out_flags,
  output logic [7:0]        out_al,
  output logic [7:0]        out_ah,
  output logic              out_flags_we,
  output logic              out_al_we,
  output logic              out_ah_we,
  output logic              out_unsupported
);
  logic              rst_s_n;
  op_kind_e          kind;
  logic [FLAG_W-1:0] flags_d, flags_q;
  logic [7:0]        al_d, al_q, ah_d, ah_q;
  logic              fwe_d, fwe_q, awe_d, awe_q, hwe_d, hwe_q, uns_d, uns_q;
  logic              cap_en;

  flag_exec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n));

  flag_exec_decode u_dec (.opcode(in_opcode), .kind(kind));

  flag_exec_datapath #(.FLAG_W(FLAG_W)) u_dp (
    .kind(kind), .op_lsb(in_opcode[0]), .valid(in_valid),
    .flags_i(in_flags), .al_i(in_al), .ah_i(in_ah),
    .flags_o(flags_d), .al_o(al_d), .ah_o(ah_d),
    .flags_we_o(fwe_d), .al_we_o(awe_d), .ah_we_o(hwe_d), .unsup_o(uns_d)
  );

  // Result stage captures every cycle; strobes are already gated by valid.
  assign cap_en = 1'b1;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      flags_q <= '0;
      al_q    <= '0;
      ah_q    <= '0;
      fwe_q   <= 1'b0;
      awe_q   <= 1'b0;
      hwe_q   <= 1'b0;
      uns_q   <= 1'b0;
    end else if (cap_en) begin
      flags_q <= flags_d;
      al_q    <= al_d;
      ah_q    <= ah_d;
      fwe_q   <= fwe_d;
      awe_q   <= awe_d;
      hwe_q   <= hwe_d;
      uns_q   <= uns_d;
    end
  end

  assign out_flags       = flags_q;
  assign out_al          = al_q;
  assign out_ah          = ah_q;
  assign out_flags_we    = fwe_q;
  assign out_al_we       = awe_q;
  assign out_ah_we       = hwe_q;
  assign out_unsupported = uns_q;

  // At most one of the strobes is active in any cycle (R9).
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({out_flags_we, out_al_we, out_ah_we, out_unsupported}));

  // An idle input cycle gives quiet strobes after the edge (R10).
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> !out_flags_we && !out_al_we && !out_ah_we && !out_unsupported);

  // Carry complement flips the carry bit (R2).
  p_cmc_flip_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && in_opcode == 8'hF5) |=> out_flags[CARRY_BIT] != $past(in_flags[CARRY_BIT]));

  // A store to AH returns the reserved slots as fixed constants (R7).
  p_ah_reserved_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_ah_we |-> (out_ah[1] && !out_ah[3] && !out_ah[5]));

  // Filling AL copies carry into every bit, with flags untouched (R8).
  p_fill_al_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_al_we |-> out_al == {8{out_flags[CARRY_BIT]}});

  // A load from AH returns the reserved flag slots as fixed constants (R6).
  p_flag_reserved_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && in_opcode == 8'h9E) |=> (out_flags[1] && !out_flags[3] && !out_flags[5]));
endmodule

// File: tb/flag_exec_unit_tb.sv
module flag_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_opcode;
  logic [FW-1:0] in_flags;
  logic [7:0]    in_al, in_ah;
  logic [FW-1:0] out_flags;
  logic [7:0]    out_al, out_ah;
  logic          out_flags_we, out_al_we, out_ah_we, out_unsupported;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_exec_unit #(.FLAG_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_flags(in_flags), .in_al(in_al), .in_ah(in_ah),
    .out_flags(out_flags), .out_al(out_al), .out_ah(out_ah),
    .out_flags_we(out_flags_we), .out_al_we(out_al_we), .out_ah_we(out_ah_we),
    .out_unsupported(out_unsupported)
  );

  function automatic logic [7:0] fixb(input logic [7:0] b);
    return {b[7], b[6], 1'b0, b[4], 1'b0, b[2], 1'b1, b[0]};
  endfunction

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'hF5:        return "R2";
      8'hF8, 8'hF9: return "R3";
      8'hFA, 8'hFB: return "R4";
      8'hFC, 8'hFD: return "R5";
      8'h9E:        return "R6";
      8'h9F:        return "R7";
      8'hD6:        return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [FW+19:0] got, input logic [FW+19:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%02h actual=%h expected=%h", req, in_opcode, got, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] op, input logic [FW-1:0] f,
                         input logic [7:0] al, input logic [7:0] ah);
    logic [FW-1:0] ef;
    logic [7:0]    eal, eah;
    logic          efw, eaw, ehw, eun;
    in_valid = 1'b1; in_opcode = op; in_flags = f; in_al = al; in_ah = ah;
    ef = f; eal = al; eah = ah; efw = 0; eaw = 0; ehw = 0; eun = 0;
    case (op)
      8'hF5:        begin ef[0] = ~f[0]; efw = 1; end
      8'hF8, 8'hF9: begin ef[0] = op[0]; efw = 1; end
      8'hFA, 8'hFB: begin ef[9] = op[0]; efw = 1; end
      8'hFC, 8'hFD: begin ef[10] = op[0]; efw = 1; end
      8'h9E:        begin ef[7:0] = fixb(ah); efw = 1; end
      8'h9F:        begin eah = fixb(f[7:0]); ehw = 1; end
      8'hD6:        begin eal = f[0] ? 8'hFF : 8'h00; eaw = 1; end
      default:      eun = 1;
    endcase
    @(negedge clk);
    check(req_of(op), {out_flags, out_al, out_ah, out_flags_we, out_al_we, out_ah_we, out_unsupported},
          {ef, eal, eah, efw, eaw, ehw, eun});
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_flags = '0; in_al = '0; in_ah = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {out_flags, out_al, out_ah, out_flags_we, out_al_we, out_ah_we, out_unsupported}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {out_flags, out_al, out_ah, out_flags_we, out_al_we, out_ah_we, out_unsupported}, '0);
    for (int p = 0; p < 6; p++) begin
      for (int o = 0; o < 256; o++) begin
        logic [FW-1:0] f;
        logic [7:0] ah, al;
        case (p)
          0: begin f = '0;        ah = 8'h00; end
          1: begin f = '1;        ah = 8'hFF; end
          2: begin f = 16'hAAAA;  ah = 8'h55; end
          3: begin f = 16'h5555;  ah = 8'hAA; end
          default: begin f = 16'(p * 16'h3B29 + o * 16'h0107); ah = 8'(o * 8'h47 + p); end
        endcase
        al = 8'(o ^ (p * 8'h1D));
        run_one(8'(o), f, al, ah);
        if ((o % 37) == 0) begin
          // R10: idle cycle gives quiet strobes
          in_valid = 1'b0;
          @(negedge clk);
          check("R10", {28'd0, out_flags_we, out_al_we, out_ah_we, out_unsupported}, '0);
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule